// File: doc/BRIEF.md
# USB Power Delivery Receive Framer and Acknowledger

This block sits behind a Power Delivery line decoder. The decoder reports the start of a packet with a 3-bit ordered-set code, then one strobe per decoded byte, then an end strobe that carries an error flag. The block stores the bytes in a local buffer. When the packet ends, it reads the 16-bit header from the first two bytes and sorts the packet into one of two kinds: an acknowledgement (GoodCRC) from the far end, or any other message.

For any other message, the block raises a message-ready pulse carrying the header, the ordered-set code and the payload length. In the same cycle it raises an acknowledge request carrying a ready-made GoodCRC header and the ordered-set type to send it on. For a received acknowledgement, it raises a single pulse carrying the acknowledged message ID. It sends no reply and delivers nothing upward.

A hard-reset input empties the buffer and is echoed as a one-cycle pulse. A byte-wide read port gives the consumer access to the stored bytes.

Top module: `pd_rx_framer`

## Requirements
- R1: After reset, msg_rdy_o, gcrc_rx_o, ack_req_o and hrst_rx_o are 0, and every held field and every buffer location reads 0.
- R2: sof_i sets the stored byte count to zero. Each later byte_vld_i writes byte_i at the next index. When a message is delivered, msg_len_o is the byte count minus 2.
- R3: The buffer holds 30 bytes. Bytes that arrive once 30 are stored are dropped, and the count stays at 30. rd_byte_o returns the byte stored at index rd_idx_i, combinationally. Indices 30 and 31 read 0.
- R4: The message header is the first stored byte as bits 7:0 and the second stored byte as bits 15:8.
- R5: eom_i with eom_err_i low, at least 2 stored bytes and a header that is not GoodCRC gives msg_rdy_o for one cycle, on the clock after eom_i. It carries msg_hdr_o, msg_type_o (the code latched at the last sof_i) and msg_len_o.
- R6: A header is GoodCRC when bit 15 is 0, bits 14:12 are 0 and bits 4:0 equal 1. Such a message gives gcrc_rx_o for one cycle, with gcrc_id_o equal to header bits 11:9. It gives neither msg_rdy_o nor ack_req_o.
- R7: eom_i with eom_err_i high gives no pulse on msg_rdy_o, gcrc_rx_o or ack_req_o.
- R8: ack_req_o pulses together with msg_rdy_o. ack_hdr_o has bit 15 = 0, bits 14:12 = 0 and bits 4:0 = 1. Bits 11:9 and bits 7:6 are copied from the received header.
- R9: When the ordered-set code is 0 (SOP), ack_hdr_o bit 8 = local_pwr_role_i and bit 5 = local_data_role_i, both sampled in the eom_i cycle. For any other code, both bits are 0.
- R10: ack_type_o equals the received ordered-set code. The reply is the 2-byte header alone.
- R11: hrst_i sets the stored byte count to zero and gives hrst_rx_o for one cycle on the next clock. It delivers no message.
- R12: eom_i with fewer than 2 stored bytes gives no pulse on msg_rdy_o, gcrc_rx_o or ack_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of packet detected |
| sof_type_i | input | 3 | Ordered-set code: 0 SOP, 1 SOP', 2 SOP'', 3 SOP' debug, 4 SOP'' debug |
| byte_vld_i | input | 1 | A decoded byte is valid |
| byte_i | input | 8 | Decoded byte |
| eom_i | input | 1 | End of packet |
| eom_err_i | input | 1 | The packet ended with an error |
| hrst_i | input | 1 | Hard reset detected on the line |
| local_pwr_role_i | input | 1 | Local power role bit |
| local_data_role_i | input | 1 | Local data role bit |
| rd_idx_i | input | 5 | Buffer read index |
| rd_byte_o | output | 8 | Buffer byte at rd_idx_i |
| msg_rdy_o | output | 1 | One-cycle pulse: a message was delivered |
| msg_hdr_o | output | 16 | Header of the delivered message |
| msg_type_o | output | 3 | Ordered-set code of the delivered message |
| msg_len_o | output | 5 | Payload length in bytes |
| gcrc_rx_o | output | 1 | One-cycle pulse: a GoodCRC was received |
| gcrc_id_o | output | 3 | Message ID of the received GoodCRC |
| ack_req_o | output | 1 | One-cycle pulse: a GoodCRC reply is requested |
| ack_hdr_o | output | 16 | Header of the GoodCRC reply |
| ack_type_o | output | 3 | Ordered-set code for the reply |
| hrst_rx_o | output | 1 | One-cycle pulse: a hard reset was received |

## Verification
The hardest situation to reach is a header that is almost a GoodCRC. The type field equals 1, but the object count is non-zero or the extended bit is set, so the message must be delivered and acknowledged. The stimulus builds exactly such headers and sends them on several ordered-set codes.

Two other cases also need deliberate stimulus:
- An overlong packet of 35 bytes, followed by a sweep of the read port across the full index range, including the two indices past the buffer.
- A hard reset that lands in the middle of a packet, followed by an end strobe that must then find an empty buffer.

// File: rtl/pd_rx_pkg.sv
package pd_rx_pkg;
  localparam int          HDR_BYTES    = 2;
  localparam logic [4:0]  GOODCRC_CODE = 5'd1;
  localparam logic [2:0]  OS_SOP       = 3'd0;

  // Acknowledgement-type check on a received header.
  function automatic logic is_goodcrc(input logic [15:0] h);
    return (h[15] == 1'b0) && (h[14:12] == 3'b000) && (h[4:0] == GOODCRC_CODE);
  endfunction

  // Reply header: ID and revision echoed; role bits only on plain SOP.
  function automatic logic [15:0] ack_header(input logic [15:0] rx,
                                             input logic pr,
                                             input logic dr,
                                             input logic [2:0] os);
    logic is_sop;
    is_sop = (os == OS_SOP);
    return {1'b0, 3'b000, rx[11:9], is_sop & pr, rx[7:6], is_sop & dr, GOODCRC_CODE};
  endfunction
endpackage

// File: rtl/pd_rx_store.sv
module pd_rx_store #(
  parameter int DEPTH = 30,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o,
  output logic [CW-1:0] count_o,
  output logic [15:0]   hdr_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          store_evt;
  logic          drop_evt;

  assign store_evt = byte_vld_i && !clear_i && (cnt_q < FULL);
  assign drop_evt  = byte_vld_i && !clear_i && (cnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (store_evt) begin
      mem_q[cnt_q[IW-1:0]] <= byte_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign hdr_o     = {mem_q[1], mem_q[0]};
  assign rd_byte_o = (int'(rd_idx_i) < DEPTH) ? mem_q[rd_idx_i] : 8'h00;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= FULL);
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) drop_evt |=> $stable(cnt_q));
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clear_i |=> cnt_q == '0);
endmodule

// File: rtl/pd_rx_classify.sv
module pd_rx_classify
  import pd_rx_pkg::*;
#(
  parameter int DEPTH = 30,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_i,
  input  logic [2:0]    sof_type_i,
  input  logic          eom_i,
  input  logic          eom_err_i,
  input  logic          hrst_i,
  input  logic          pr_i,
  input  logic          dr_i,
  input  logic [CW-1:0] count_i,
  input  logic [15:0]   hdr_i,
  output logic          msg_rdy_o,
  output logic [15:0]   msg_hdr_o,
  output logic [2:0]    msg_type_o,
  output logic [CW-1:0] msg_len_o,
  output logic          gcrc_rx_o,
  output logic [2:0]    gcrc_id_o,
  output logic          ack_req_o,
  output logic [15:0]   ack_hdr_o,
  output logic [2:0]    ack_type_o,
  output logic          hrst_rx_o
);
  localparam logic [CW-1:0] HDR_C = CW'(HDR_BYTES);

  logic [2:0] os_q;
  logic       accept_evt;
  logic       ack_seen;
  logic       deliver_evt;
  logic       gcrc_evt;

  assign accept_evt  = eom_i && !eom_err_i && (count_i >= HDR_C);
  assign ack_seen    = is_goodcrc(hdr_i);
  assign deliver_evt = accept_evt && !ack_seen;
  assign gcrc_evt    = accept_evt && ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q       <= '0;
      msg_rdy_o  <= 1'b0;
      msg_hdr_o  <= '0;
      msg_type_o <= '0;
      msg_len_o  <= '0;
      gcrc_rx_o  <= 1'b0;
      gcrc_id_o  <= '0;
      ack_req_o  <= 1'b0;
      ack_hdr_o  <= '0;
      ack_type_o <= '0;
      hrst_rx_o  <= 1'b0;
    end else begin
      if (sof_i) os_q <= sof_type_i;
      msg_rdy_o <= deliver_evt;
      ack_req_o <= deliver_evt;
      gcrc_rx_o <= gcrc_evt;
      hrst_rx_o <= hrst_i;
      if (deliver_evt) begin
        msg_hdr_o  <= hdr_i;
        msg_type_o <= os_q;
        msg_len_o  <= count_i - HDR_C;
        ack_hdr_o  <= ack_header(hdr_i, pr_i, dr_i, os_q);
        ack_type_o <= os_q;
      end
      if (gcrc_evt) gcrc_id_o <= hdr_i[11:9];
    end
  end

  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_i && eom_err_i) |=> (!msg_rdy_o && !gcrc_rx_o && !ack_req_o));
  // R12
  runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_i && count_i < HDR_C) |=> (!msg_rdy_o && !gcrc_rx_o));
  // R6
  gcrc_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcrc_rx_o |-> (!ack_req_o && !msg_rdy_o));
  // R8
  ack_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (ack_hdr_o[15:12] == 4'h0 && ack_hdr_o[4:0] == 5'd1 &&
                   ack_hdr_o[11:9] == msg_hdr_o[11:9] && ack_hdr_o[7:6] == msg_hdr_o[7:6]));
  // R9
  nonsop_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && ack_type_o != 3'd0) |-> (ack_hdr_o[8] == 1'b0 && ack_hdr_o[5] == 1'b0));
  // R10
  ack_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> ack_type_o == msg_type_o);
  // R11
  hrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_i |=> hrst_rx_o);
  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_rdy_o, gcrc_rx_o}));
endmodule

// File: rtl/pd_rx_framer.sv
module pd_rx_framer #(
  parameter int DEPTH = 30,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_i,
  input  logic [2:0]    sof_type_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          eom_i,
  input  logic          eom_err_i,
  input  logic          hrst_i,
  input  logic          local_pwr_role_i,
  input  logic          local_data_role_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o,
  output logic          msg_rdy_o,
  output logic [15:0]   msg_hdr_o,
  output logic [2:0]    msg_type_o,
  output logic [CW-1:0] msg_len_o,
  output logic          gcrc_rx_o,
  output logic [2:0]    gcrc_id_o,
  output logic          ack_req_o,
  output logic [15:0]   ack_hdr_o,
  output logic [2:0]    ack_type_o,
  output logic          hrst_rx_o
);
  logic          buf_clear;
  logic [CW-1:0] buf_count;
  logic [15:0]   buf_hdr;

  assign buf_clear = sof_i || hrst_i;

  pd_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (buf_clear),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_idx_i   (rd_idx_i),
    .rd_byte_o  (rd_byte_o),
    .count_o    (buf_count),
    .hdr_o      (buf_hdr)
  );

  pd_rx_classify #(.DEPTH(DEPTH)) u_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .sof_type_i (sof_type_i),
    .eom_i      (eom_i),
    .eom_err_i  (eom_err_i),
    .hrst_i     (hrst_i),
    .pr_i       (local_pwr_role_i),
    .dr_i       (local_data_role_i),
    .count_i    (buf_count),
    .hdr_i      (buf_hdr),
    .msg_rdy_o  (msg_rdy_o),
    .msg_hdr_o  (msg_hdr_o),
    .msg_type_o (msg_type_o),
    .msg_len_o  (msg_len_o),
    .gcrc_rx_o  (gcrc_rx_o),
    .gcrc_id_o  (gcrc_id_o),
    .ack_req_o  (ack_req_o),
    .ack_hdr_o  (ack_hdr_o),
    .ack_type_o (ack_type_o),
    .hrst_rx_o  (hrst_rx_o)
  );
endmodule

// File: tb/pd_rx_framer_bench.sv
`timescale 1ns/1ps
module pd_rx_framer_bench;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 0, bv = 0, eom = 0, err = 0, hrst = 0, pr = 0, dr = 0;
  logic [2:0] typ = 0;
  logic [7:0] bd = 0;
  logic [4:0] ridx = 0;
  logic [7:0] rd_byte;
  logic msg_rdy, gcrc_rx, ack_req, hrst_rx;
  logic [15:0] msg_hdr, ack_hdr;
  logic [2:0] msg_type, gcrc_id, ack_type;
  logic [4:0] msg_len;

  always #2.5 clk = ~clk;

  pd_rx_framer u_pd_rx_framer (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .sof_type_i(typ), .byte_vld_i(bv),
    .byte_i(bd), .eom_i(eom), .eom_err_i(err), .hrst_i(hrst),
    .local_pwr_role_i(pr), .local_data_role_i(dr), .rd_idx_i(ridx),
    .rd_byte_o(rd_byte), .msg_rdy_o(msg_rdy), .msg_hdr_o(msg_hdr),
    .msg_type_o(msg_type), .msg_len_o(msg_len), .gcrc_rx_o(gcrc_rx),
    .gcrc_id_o(gcrc_id), .ack_req_o(ack_req), .ack_hdr_o(ack_hdr),
    .ack_type_o(ack_type), .hrst_rx_o(hrst_rx)
  );

  int vectors = 0;
  int miss = 0;
  string scn = "R1 reset";

  // Behavioural reference state
  int mm[30];
  int cnt = 0;
  int os = 0;
  int e_rdy = 0, e_hdr = 0, e_type = 0, e_len = 0, e_gc = 0, e_gid = 0;
  int e_ack = 0, e_ackh = 0, e_ackt = 0, e_hr = 0;

  task automatic chk(string tag, string f, int act, int exp);
    vectors++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s [%s]: actual %0h expected %0h", tag, f, scn, act, exp);
    end
  endtask

  task automatic model();
    int h;
    bit gc;
    e_rdy = 0; e_gc = 0; e_ack = 0; e_hr = 0;
    if (eom && !err && cnt >= 2) begin
      h = mm[0] + 256 * mm[1];
      gc = ((h / 32768) == 0) && (((h / 4096) % 8) == 0) && ((h % 32) == 1);
      if (gc) begin
        e_gc = 1; e_gid = (h / 512) % 8;
      end else begin
        e_rdy = 1; e_hdr = h; e_type = os; e_len = cnt - 2;
        e_ack = 1; e_ackt = os;
        e_ackh = 1 + 512 * ((h / 512) % 8) + 64 * ((h / 64) % 4);
        if (os == 0) e_ackh += 256 * int'(pr) + 32 * int'(dr);
      end
    end
    if (hrst) e_hr = 1;
    if (sof) os = typ;
    if (sof || hrst) cnt = 0;
    else if (bv && cnt < 30) begin mm[cnt] = bd; cnt++; end
  endtask

  task automatic compare();
    chk("R5", "msg_rdy", msg_rdy, e_rdy);
    chk("R4", "msg_hdr", msg_hdr, e_hdr);
    chk("R5", "msg_type", msg_type, e_type);
    chk("R2", "msg_len", msg_len, e_len);
    chk("R6", "gcrc_rx", gcrc_rx, e_gc);
    chk("R6", "gcrc_id", gcrc_id, e_gid);
    chk("R8", "ack_req", ack_req, e_ack);
    chk("R8", "ack_hdr", ack_hdr, e_ackh);
    chk("R10", "ack_type", ack_type, e_ackt);
    chk("R11", "hrst_rx", hrst_rx, e_hr);
    chk("R3", "rd_byte", rd_byte, (ridx < 30) ? mm[ridx] : 0);
  endtask

  task automatic step();
    @(posedge clk);
    model();
    #1;
    compare();
  endtask

  task automatic send(input logic [2:0] t, input bq_t b, input logic e);
    sof = 1; typ = t; step(); sof = 0;
    foreach (b[i]) begin bv = 1; bd = b[i]; step(); end
    bv = 0;
    eom = 1; err = e; step(); eom = 0; err = 0;
    step();
  endtask

  function automatic bq_t mk(input logic [15:0] h, input int n);
    bq_t q;
    q.push_back(h[7:0]);
    q.push_back(h[15:8]);
    for (int i = 2; i < n; i++) q.push_back(8'(i * 13 + 5));
    return q;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    bq_t q;
    for (int i = 0; i < 30; i++) mm[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    scn = "R1 reset";
    step(); step();
    // R9: SOP with roles set, data message (count 1)
    scn = "R9 sop roles"; pr = 1; dr = 1;
    send(3'd0, mk(16'h1A86, 6), 1'b0);
    // R9: SOP' gives zero role bits
    scn = "R9 sop-prime roles";
    send(3'd1, mk(16'h5D43, 2), 1'b0);
    // R6: GoodCRC id 5
    scn = "R6 goodcrc";
    send(3'd0, mk(16'h0A41, 2), 1'b0);
    // R6 boundary: type 1 with count nonzero, and extended bit set
    scn = "R6 near-goodcrc count";
    send(3'd2, mk(16'h1641, 6), 1'b0);
    scn = "R6 near-goodcrc ext";
    send(3'd0, mk(16'h8441, 2), 1'b0);
    // R7: error-terminated message
    scn = "R7 error";
    send(3'd0, mk(16'h0206, 4), 1'b1);
    scn = "R7 error goodcrc";
    send(3'd0, mk(16'h0601, 2), 1'b1);
    // R3: overlong packet, then read sweep
    scn = "R3 overlong"; pr = 0; dr = 1;
    send(3'd0, mk(16'h7E2F, 35), 1'b0);
    for (int i = 0; i < 32; i++) begin ridx = 5'(i); step(); end
    ridx = 0;
    // R12: runt packets
    scn = "R12 runt";
    q = {8'h41}; send(3'd0, q, 1'b0);
    q = {}; send(3'd0, q, 1'b0);
    // R11: hard reset mid message
    scn = "R11 hard reset";
    sof = 1; typ = 0; step(); sof = 0;
    bv = 1; bd = 8'h46; step(); bd = 8'h12; step(); bv = 0;
    hrst = 1; step(); hrst = 0;
    eom = 1; step(); eom = 0; step();
    // R10: debug ordered sets with revision bits
    scn = "R10 debug sop"; pr = 1; dr = 0;
    send(3'd4, mk(16'h2CC3, 10), 1'b0);
    send(3'd3, mk(16'h0E8F, 2), 1'b0);
    scn = "R2 back-to-back";
    send(3'd0, mk(16'h73D7, 30), 1'b0);
    send(3'd0, mk(16'h0C01, 2), 1'b0);
    for (int i = 0; i < 4; i++) begin ridx = 5'(i * 9); step(); end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule